// File: doc/BRIEF.md
# Video Payload Identifier Inserter

This block sits in the parallel path of a 10-bit HD video transmitter. It watches the luma stream for the end-of-active-video timing marker. When the marker falls on the line chosen for the current format and field, it overlays a short ancillary packet in the luma words that follow. The packet carries four payload identifier bytes that describe the picture format. Every other word, and the whole chroma stream, goes through with one register of delay.

The target line depends on a 3-bit format code. Interlaced formats get one packet in each field: 625i uses lines 9 and 322, and 1080i uses lines 10 and 572. Progressive formats get one packet per frame: 525p on line 13, 625p on line 9, and 720p and 1080p on line 10. A static parameter removes the inserter completely, leaving a plain registered pass-through.

A flag output marks each luma word that the block replaced. Downstream logic can use it to spot the packet without decoding it.

Top module: `pid_inserter`

## Requirements
- R1: While reset is high, on the clock edge `y_out`, `c_out` and `ins_flag` are all cleared to zero.
- R2: Any luma word not replaced by a packet appears on `y_out` exactly one clock after it is presented on `y_in`.
- R3: `c_out` always equals the `c_in` value of the previous clock; chroma is never modified.
- R4: Interlaced formats insert one packet per field. With `fmt_sel` 0 (625i) the packet goes on line 9 when `field_two`=0 and on line 322 when `field_two`=1. With `fmt_sel` 1 (1080i) it goes on line 10 when `field_two`=0 and on line 572 when `field_two`=1.
- R5: Progressive formats ignore `field_two`. The packet goes on line 13 for `fmt_sel` 2 (525p), line 9 for 3 (625p), line 10 for 4 (720p) and line 10 for 5 (1080p). Codes 6 and 7 never insert.
- R6: A packet replaces the 11 luma input words that follow the cycle in which `eav_mark` is high on a target line. `ins_flag` is high for exactly those 11 output words and low for all others. A marker seen while a packet is in progress starts nothing.
- R7: The first three packet words are 0x000, 0x3FF, 0x3FF. They are followed by the identifier word for 0x41, the secondary identifier word for 0x01, and the count word for 4.
- R8: Words 7 to 10 of the packet carry `pay_b0` to `pay_b3` in that order. Each identifier, count and payload word holds its byte in bits 7:0, the even parity of bits 7:0 in bit 8, and the inverse of bit 8 in bit 9.
- R9: The 11th word is the checksum. Bits 8:0 are the 9-bit sum, modulo 512, of bits 8:0 of packet words 4 to 10, and bit 9 is the inverse of bit 8.
- R10: The payload bytes are captured in the cycle of the triggering marker. Changes on `pay_b0` to `pay_b3` after that cycle do not alter the packet in progress.
- R11: With the parameter `INSERT_EN` = 0, `y_out` is always the previous `y_in` and `ins_flag` stays 0.
- R12: Markers on non-target lines, or on the wrong field's line, leave the luma stream unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video word clock |
| rst | input | 1 | Synchronous active-high reset |
| y_in | input | 10 | Luma word in |
| c_in | input | 10 | Chroma word in |
| line_num | input | 11 | Current line number, valid at the marker |
| field_two | input | 1 | 0 = first field, 1 = second field |
| eav_mark | input | 1 | High on the last word of the end-of-active-video sequence |
| fmt_sel | input | 3 | Format code: 0 625i, 1 1080i, 2 525p, 3 625p, 4 720p, 5 1080p |
| pay_b0 | input | 8 | Payload byte 1 |
| pay_b1 | input | 8 | Payload byte 2 |
| pay_b2 | input | 8 | Payload byte 3 |
| pay_b3 | input | 8 | Payload byte 4 |
| y_out | output | 10 | Luma word out, packet overlaid |
| c_out | output | 10 | Chroma word out |
| ins_flag | output | 1 | High on replaced luma words |

## Verification
Every output is due exactly one clock after the input word it belongs to. A packet triggered by a marker in cycle t therefore appears on `y_out` in cycles t+2 to t+12. The bench drives new inputs just after each falling edge. At that same falling edge, before driving, it compares all outputs against the prediction its model made for the inputs of the previous cycle. The prediction comes from a pending-word counter and a packet the model builds itself. After each synthetic line, the bench also counts flagged words and compares the count with 11 on the target line and 0 elsewhere.

// File: rtl/pid_pkg.sv
package pid_pkg;

    localparam int WORD_W = 10;
    localparam int LINE_W = 11;
    localparam int PKT_WORDS = 11;

    typedef enum logic [2:0] {
        FMT_625I  = 3'd0,
        FMT_1080I = 3'd1,
        FMT_525P  = 3'd2,
        FMT_625P  = 3'd3,
        FMT_720P  = 3'd4,
        FMT_1080P = 3'd5
    } vfmt_e;

    typedef struct packed {
        logic [WORD_W-1:0] y;
        logic              ins;
    } luma_t;

    // Line on which the packet belongs; zero means no insertion.
    function automatic logic [LINE_W-1:0] target_line(input logic [2:0] fmt, input logic second);
        case (fmt)
            FMT_625I:  return second ? LINE_W'(322) : LINE_W'(9);
            FMT_1080I: return second ? LINE_W'(572) : LINE_W'(10);
            FMT_525P:  return LINE_W'(13);
            FMT_625P:  return LINE_W'(9);
            FMT_720P,
            FMT_1080P: return LINE_W'(10);
            default:   return '0;
        endcase
    endfunction

    // 8-bit value with even parity in bit 8 and its inverse in bit 9.
    function automatic logic [WORD_W-1:0] anc_word(input logic [7:0] v);
        logic p;
        p = ^v;
        return {~p, p, v};
    endfunction

endpackage

// File: rtl/pid_line_match.sv
module pid_line_match
    import pid_pkg::*;
(
    input  logic [2:0]        fmt_sel,
    input  logic              field_two,
    input  logic [LINE_W-1:0] line_num,
    output logic              hit
);
    logic [LINE_W-1:0] want;

    always_comb begin
        want = target_line(fmt_sel, field_two);
        hit  = (want != '0) && (line_num == want);
    end
endmodule

// File: rtl/pid_packet_gen.sv
module pid_packet_gen
    import pid_pkg::*;
#(
    parameter logic [7:0] DID_VAL  = 8'h41,
    parameter logic [7:0] SDID_VAL = 8'h01,
    parameter int         N_BYTES  = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   trigger,
    input  logic [N_BYTES-1:0][7:0] bytes_in,
    output logic                   active,
    output logic [WORD_W-1:0]      word
);
    localparam int N_WORDS = 3 + 3 + N_BYTES + 1;
    localparam int IDX_W   = $clog2(N_WORDS + 1);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_WORDS);

    logic [IDX_W-1:0]          idx;
    logic [N_BYTES-1:0][7:0]   held;
    logic [WORD_W-1:0]         body [N_BYTES+3];
    logic [8:0]                sum;

    assign active = (idx != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx  <= '0;
            held <= '0;
        end else if (!active) begin
            if (trigger) begin
                idx  <= IDX_W'(1);
                held <= bytes_in;
            end
        end else begin
            idx <= (idx == LAST) ? '0 : idx + IDX_W'(1);
        end
    end

    // Identifier, count and payload words; checksum over their low 9 bits.
    always_comb begin
        body[0] = anc_word(DID_VAL);
        body[1] = anc_word(SDID_VAL);
        body[2] = anc_word(8'(N_BYTES));
        sum     = '0;
        for (int k = 0; k < N_BYTES; k++) begin
            body[k+3] = anc_word(held[k]);
        end
        for (int k = 0; k < N_BYTES + 3; k++) begin
            sum = sum + body[k][8:0];
        end
    end

    always_comb begin
        if (idx == IDX_W'(1)) begin
            word = '0;
        end else if (idx == IDX_W'(2) || idx == IDX_W'(3)) begin
            word = '1;
        end else if (idx == LAST) begin
            word = {~sum[8], sum};
        end else if (idx >= IDX_W'(4)) begin
            word = body[int'(idx) - 4];
        end else begin
            word = '0;
        end
    end

    // R6: the word index walks up by one until the last word, then returns to idle
    a_r6_index_walk: assert property (@(posedge clk) disable iff (rst)
        active |=> ((idx == $past(idx) + IDX_W'(1)) || (idx == '0 && $past(idx) == LAST)));

    // R10: captured bytes hold still for the whole packet
    a_r10_bytes_hold: assert property (@(posedge clk) disable iff (rst)
        active |=> $stable(held));
endmodule

// File: rtl/pid_inserter.sv
module pid_inserter
    import pid_pkg::*;
#(
    parameter bit INSERT_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [9:0]        y_in,
    input  logic [9:0]        c_in,
    input  logic [10:0]       line_num,
    input  logic              field_two,
    input  logic              eav_mark,
    input  logic [2:0]        fmt_sel,
    input  logic [7:0]        pay_b0,
    input  logic [7:0]        pay_b1,
    input  logic [7:0]        pay_b2,
    input  logic [7:0]        pay_b3,
    output logic [9:0]        y_out,
    output logic [9:0]        c_out,
    output logic              ins_flag
);
    luma_t nxt;

    generate
        if (INSERT_EN) begin : g_ins
            logic              hit;
            logic              busy;
            logic [WORD_W-1:0] pkt_word;

            pid_line_match u_match (
                .fmt_sel   (fmt_sel),
                .field_two (field_two),
                .line_num  (line_num),
                .hit       (hit)
            );

            pid_packet_gen #(.N_BYTES(4)) u_gen (
                .clk      (clk),
                .rst      (rst),
                .trigger  (eav_mark && hit),
                .bytes_in ({pay_b3, pay_b2, pay_b1, pay_b0}),
                .active   (busy),
                .word     (pkt_word)
            );

            always_comb begin
                nxt.ins = busy;
                nxt.y   = busy ? pkt_word : y_in;
            end
        end else begin : g_pass
            always_comb begin
                nxt.ins = 1'b0;
                nxt.y   = y_in;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            y_out    <= '0;
            c_out    <= '0;
            ins_flag <= 1'b0;
        end else begin
            y_out    <= nxt.y;
            c_out    <= c_in;
            ins_flag <= nxt.ins;
        end
    end

    // R3: chroma is a pure one-cycle delay
    a_r3_chroma_delay: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> c_out == $past(c_in));

    // R2: unflagged luma is the previous input word
    a_r2_luma_pass: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !ins_flag) |-> y_out == $past(y_in));

    // R7: a packet opens with the all-zero flag word
    a_r7_first_word: assert property (@(posedge clk) disable iff (rst)
        $rose(ins_flag) |-> y_out == 10'h000);

    // R11: disabled build never flags a word
    a_r11_no_flag_when_off: assert property (@(posedge clk) disable iff (rst)
        !INSERT_EN |-> !ins_flag);
endmodule

// File: tb/pid_inserter_bench.sv
module pid_inserter_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] y_in = '0, c_in = '0;
    logic [10:0] line_num = '0;
    logic       field_two = 1'b0, eav_mark = 1'b0;
    logic [2:0] fmt_sel = '0;
    logic [7:0] pay_b0 = '0, pay_b1 = '0, pay_b2 = '0, pay_b3 = '0;
    logic [9:0] y_out, c_out, y_off, c_off;
    logic       ins_flag, flag_off;

    int checks = 0, failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pid_inserter u_pid_inserter (
        .clk(clk), .rst(rst), .y_in(y_in), .c_in(c_in), .line_num(line_num),
        .field_two(field_two), .eav_mark(eav_mark), .fmt_sel(fmt_sel),
        .pay_b0(pay_b0), .pay_b1(pay_b1), .pay_b2(pay_b2), .pay_b3(pay_b3),
        .y_out(y_out), .c_out(c_out), .ins_flag(ins_flag));

    pid_inserter #(.INSERT_EN(1'b0)) u_pid_inserter_off (
        .clk(clk), .rst(rst), .y_in(y_in), .c_in(c_in), .line_num(line_num),
        .field_two(field_two), .eav_mark(eav_mark), .fmt_sel(fmt_sel),
        .pay_b0(pay_b0), .pay_b1(pay_b1), .pay_b2(pay_b2), .pay_b3(pay_b3),
        .y_out(y_off), .c_out(c_off), .ins_flag(flag_off));

    // reference model state
    int         pend = 0;
    logic [9:0] pkt [11];
    logic [9:0] exp_y, exp_c, exp_pass;
    logic       exp_f;
    int         exp_pos;
    bit         exp_valid = 0;
    bit         r10_phase = 0;
    int         line_flags = 0;

    function automatic int where_packet(input int fmt, input bit second);
        if (fmt == 0) return second ? 322 : 9;
        if (fmt == 1) return second ? 572 : 10;
        if (fmt == 2) return 13;
        if (fmt == 3) return 9;
        if (fmt == 4 || fmt == 5) return 10;
        return -1;
    endfunction

    function automatic logic [9:0] enc(input logic [7:0] v);
        int ones = 0;
        for (int i = 0; i < 8; i++) ones += v[i];
        return (ones % 2 == 1) ? {2'b01, v} : {2'b10, v};
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, expv, $time);
        end
    endtask

    task automatic build_packet();
        logic [7:0] b [4];
        int s = 0;
        b[0] = pay_b0; b[1] = pay_b1; b[2] = pay_b2; b[3] = pay_b3;
        pkt[0] = 10'h000; pkt[1] = 10'h3FF; pkt[2] = 10'h3FF;
        pkt[3] = enc(8'h41); pkt[4] = enc(8'h01); pkt[5] = enc(8'd4);
        for (int i = 0; i < 4; i++) pkt[6+i] = enc(b[i]);
        for (int i = 3; i < 10; i++) s += pkt[i][8:0];
        s = s % 512;
        pkt[10] = {~s[8], s[8:0]};
    endtask

    task automatic step(input logic [9:0] y, input logic [9:0] c, input bit mark);
        bit busy;
        string ytag;
        @(negedge clk);
        if (exp_valid) begin
            if (exp_f) ytag = (exp_pos < 3) ? "R7" : (exp_pos == 10) ? "R9" : (r10_phase ? "R10" : "R8");
            else ytag = "R2";
            check(y_out == exp_y, ytag, y_out, exp_y);
            check(c_out == exp_c, "R3", c_out, exp_c);
            check(ins_flag == exp_f, "R6", ins_flag, exp_f);
            check(y_off == exp_pass && !flag_off, "R11", {flag_off, y_off}, exp_pass);
            if (ins_flag) line_flags++;
        end
        if (r10_phase) begin
            pay_b0 = 8'($urandom); pay_b1 = 8'($urandom);
            pay_b2 = 8'($urandom); pay_b3 = 8'($urandom);
        end
        y_in = y; c_in = c; eav_mark = mark;
        busy = (pend > 0);
        if (busy) begin
            exp_pos = 11 - pend;
            exp_y = pkt[exp_pos];
            exp_f = 1'b1;
            pend--;
        end else begin
            exp_y = y;
            exp_f = 1'b0;
        end
        if (mark && !busy && where_packet(int'(fmt_sel), field_two) == int'(line_num)) begin
            build_packet();
            pend = 11;
        end
        exp_c = c; exp_pass = y; exp_valid = 1;
    endtask

    task automatic run_line(input int fmt, input bit second, input int ln);
        int want, tgt;
        fmt_sel = 3'(fmt); field_two = second; line_num = 11'(ln);
        if (!r10_phase) begin
            pay_b0 = 8'(ln * 3 + 1); pay_b1 = 8'(fmt * 37);
            pay_b2 = 8'(8'hA5 ^ 8'(ln)); pay_b3 = 8'(ln + fmt);
        end
        line_flags = 0;
        step(10'h3FF, 10'h200, 0);
        step(10'h000, 10'h201, 0);
        step(10'h000, 10'h202, 0);
        step(10'h274, 10'h203, 1);
        for (int w = 4; w < 40; w++)
            step(10'((ln * 7 + w * 13 + fmt) & 10'h3FF), 10'((w * 5 + ln) & 10'h3FF), (w == 9));
        tgt  = where_packet(fmt, second);
        want = (tgt == ln) ? 11 : 0;
        if (fmt <= 1)           check(line_flags == want, (want != 0) ? "R4" : "R12", line_flags, want);
        else if (want != 0)     check(line_flags == want, "R5", line_flags, want);
        else                    check(line_flags == want, (fmt <= 5) ? "R12" : "R5", line_flags, want);
    endtask

    initial begin
        int lines [7] = '{8, 9, 10, 11, 13, 322, 572};
        y_in = 10'h155; c_in = 10'h2AA;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(y_out == 0 && c_out == 0 && !ins_flag, "R1", {ins_flag, y_out}, 0);
        check(y_off == 0 && !flag_off, "R1", {flag_off, y_off}, 0);
        rst = 1'b0;
        for (int f = 0; f < 8; f++)
            for (int s = 0; s < 2; s++)
                for (int l = 0; l < 7; l++)
                    run_line(f, s[0], lines[l]);
        r10_phase = 1;
        run_line(5, 0, 10);
        run_line(1, 1, 572);
        r10_phase = 0;
        step(10'h040, 10'h040, 0);
        step(10'h041, 10'h041, 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule